// File: doc/BRIEF.md
# Frame Sequence Divider with Resync

This block counts output video frames and emits a one-clock marker at the start of every n-th frame. n is 5 at the 30 and 29.97 frame-per-second rates and 10 at the 60 and 59.94 rates. A second, independent frame counter with a register-loaded period of 1 to 16 frames produces an audio-frame-sequence marker. Both counters advance only on a strobe that marks the leading edge of the output horizontal sync on line 1, so every marker is aligned to that point in the frame.

An external, asynchronous resync input realigns the sequence. It passes through a synchroniser and is held as a pending request for the rest of the frame. At the next line-1 strobe the request restarts the video counter, issues a one-clock phase-reset strobe to the downstream audio clock dividers, and restarts the audio counter as well unless a control bit excludes it. With resync held low, both counters free-run.

Top module: `frame_seq_divider`

## Requirements
- R1: While and after reset, with no line-1 strobe yet, all three outputs are low. Both counters start at frame index 0 and the latched rate is the slow one.
- R2: With `rate_fast` = 0 and no resync, `vid_seq_mark` pulses on exactly one of every 5 consecutive line-1 strobes.
- R3: With `rate_fast` = 1 and no resync, `vid_seq_mark` pulses on exactly one of every 10 consecutive line-1 strobes.
- R4: `rate_fast` is sampled only at a line-1 strobe. A value that differs from the latched rate reloads the video counter to index 0 at that strobe, which pulses `vid_seq_mark`.
- R5: The resync level, seen through a two-flop synchroniser, restarts the video counter at the line-1 strobe. This includes a level that reaches the synchroniser output in the very cycle of the strobe. `vid_seq_mark` then pulses for that frame.
- R6: Every applied resync pulses `aud_phase_rst` in the same cycle as `vid_seq_mark`.
- R7: With `resync_aud_en` = 1 at the strobe, an applied resync also restarts the audio counter, so `aud_seq_mark` pulses in that cycle.
- R8: With `resync_aud_en` = 0, an applied resync leaves the audio counter's sequence unchanged.
- R9: The audio period is `aud_len_m1`+1 frames (1 to 16). `aud_seq_mark` pulses when the audio counter wraps from `aud_len_m1` or above to 0.
- R10: With resync low, both counters free-run and advance by one per line-1 strobe.
- R11: Each marker and the phase-reset strobe is high for exactly the one clock after the line-1 strobe, and low otherwise.
- R12: A pending resync is cleared when it is applied. A resync that reaches the synchroniser output only after a strobe is applied at the following strobe, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line1_stb | input | 1 | One-clock strobe at the horizontal sync leading edge of output line 1 |
| rate_fast | input | 1 | 0: 5-frame sequence (30/29.97 fps), 1: 10-frame sequence (60/59.94 fps) |
| resync_in | input | 1 | Asynchronous sequence resync request |
| resync_aud_en | input | 1 | 1: resync also restarts the audio counter |
| aud_len_m1 | input | AUD_W | Audio sequence length minus one |
| vid_seq_mark | output | 1 | Video frame-sequence marker pulse |
| aud_seq_mark | output | 1 | Audio frame-sequence marker pulse |
| aud_phase_rst | output | 1 | Phase-reset strobe for the audio clock dividers |

## Verification
Two events can land on the same clock edge: the resync request leaving the synchroniser, and the line-1 strobe. The bench raises `resync_in` for one cycle, timed so that the synchronised level appears exactly at the strobe edge, and expects the restart in that same frame. It then raises `resync_in` on the strobe cycle itself and expects the restart only at the following strobe. A rate change and a resync are also made to meet at one strobe. All outcomes are judged against a frame-level model of the two counters.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  typedef enum logic {RATE_SLOW = 1'b0, RATE_FAST = 1'b1} rate_e;

  // Frame index that follows cur: 0 on a forced restart or past the last index.
  function automatic int unsigned next_index(input int unsigned cur,
                                             input int unsigned last,
                                             input logic        restart);
    if (restart || cur >= last) return 0;
    return cur + 1;
  endfunction

  // Last frame index of the video sequence for a given rate.
  function automatic int unsigned vid_last_index(input rate_e       rate,
                                                 input int unsigned slow_n,
                                                 input int unsigned fast_n);
    return (rate == RATE_FAST) ? fast_n - 1 : slow_n - 1;
  endfunction

endpackage

// File: rtl/fsd_sync.sv
module fsd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic line1_stb,
  output logic rs_now,
  output logic pending,
  output logic apply
);

  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign rs_now = chain[STAGES-1];
  assign apply  = line1_stb & (pending | rs_now);

  always_ff @(posedge clk) begin
    if (!rst_n)         pending <= 1'b0;
    else if (line1_stb) pending <= 1'b0;
    else if (rs_now)    pending <= 1'b1;
  end

  // R12: a request is consumed at every strobe
  p_pend_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line1_stb) |-> !pending);

  // R5: a pending request only appears from the synchronised level
  p_pend_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(rs_now));

endmodule

// File: rtl/fsd_div.sv
module fsd_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic         restart,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         mark
);

  logic [W-1:0] nxt;
  logic         wrap_now;

  always_comb begin
    nxt      = W'(fsd_pkg::next_index(32'(cnt), 32'(last), restart));
    wrap_now = stb && (nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      mark <= 1'b0;
    end else begin
      if (stb) cnt <= nxt;
      mark <= wrap_now;
    end
  end

  // R10: the counter moves only on a line-1 strobe
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb) |-> $stable(cnt));

  // R11: a marker follows a strobe by one clock
  p_mark_after_stb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mark |-> $past(stb));

  // R5: a forced restart lands on index 0 with a marker
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb && restart) |-> (cnt == '0) && mark);

endmodule

// File: rtl/frame_seq_divider.sv
module frame_seq_divider #(
  parameter int SLOW_FRAMES = 5,
  parameter int FAST_FRAMES = 10,
  parameter int AUD_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line1_stb,
  input  logic             rate_fast,
  input  logic             resync_in,
  input  logic             resync_aud_en,
  input  logic [AUD_W-1:0] aud_len_m1,
  output logic             vid_seq_mark,
  output logic             aud_seq_mark,
  output logic             aud_phase_rst
);
  import fsd_pkg::*;

  localparam int VID_W = $clog2(FAST_FRAMES);

  rate_e            rate_q;
  rate_e            rate_in;
  logic             rate_chg;
  logic [VID_W-1:0] vid_last;
  logic [VID_W-1:0] vid_cnt;
  logic [AUD_W-1:0] aud_cnt;
  logic             rs_now;
  logic             rs_pending;
  logic             rs_apply;
  logic             vid_restart;
  logic             aud_restart;

  fsd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (resync_in),
    .line1_stb (line1_stb),
    .rs_now    (rs_now),
    .pending   (rs_pending),
    .apply     (rs_apply)
  );

  always_comb begin
    rate_in     = rate_e'(rate_fast);
    rate_chg    = line1_stb && (rate_in != rate_q);
    vid_last    = VID_W'(vid_last_index(rate_in, SLOW_FRAMES, FAST_FRAMES));
    vid_restart = rs_apply | rate_chg;
    aud_restart = rs_apply & resync_aud_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q        <= RATE_SLOW;
      aud_phase_rst <= 1'b0;
    end else begin
      if (line1_stb) rate_q <= rate_in;
      aud_phase_rst <= rs_apply;
    end
  end

  fsd_div #(.W(VID_W)) u_vid_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (line1_stb),
    .restart (vid_restart),
    .last    (vid_last),
    .cnt     (vid_cnt),
    .mark    (vid_seq_mark)
  );

  fsd_div #(.W(AUD_W)) u_aud_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (line1_stb),
    .restart (aud_restart),
    .last    (aud_len_m1),
    .cnt     (aud_cnt),
    .mark    (aud_seq_mark)
  );

  // R6: phase reset always accompanies a video marker
  p_phase_vid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    aud_phase_rst |-> vid_seq_mark);

  // R7: with the mask bit set, phase reset restarts the audio sequence too
  p_mask_aud_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (aud_phase_rst && $past(resync_aud_en)) |-> (aud_seq_mark && aud_cnt == '0));

  // R4: a rate change at the strobe reloads the video counter
  p_rate_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line1_stb && (rate_fast != rate_q)) |-> (vid_seq_mark && vid_cnt == '0));

  // R2/R3 bound: the video index never exceeds the latched rate's last index
  p_vid_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(vid_cnt) <= ((rate_q == RATE_FAST) ? FAST_FRAMES - 1 : SLOW_FRAMES - 1));

  // R12: the sync output alone never produces a phase reset without a strobe
  p_phase_stb_r12: assert property (@(posedge clk) disable iff (!rst_n)
    aud_phase_rst |-> $past(line1_stb && (rs_pending || rs_now)));

endmodule

// File: tb/frame_seq_divider_tb.sv
`timescale 1ns/1ps
module frame_seq_divider_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line1_stb = 1'b0;
  logic       rate_fast = 1'b0;
  logic       resync_in = 1'b0;
  logic       resync_aud_en = 1'b1;
  logic [3:0] aud_len_m1 = 4'd2;
  logic       vid_seq_mark, aud_seq_mark, aud_phase_rst;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  int m_vid = 0;
  int m_aud = 0;
  bit m_rate = 1'b0;
  bit m_carry = 1'b0;

  always #2.5 clk = ~clk;

  frame_seq_divider u_dut (
    .clk(clk), .rst_n(rst_n), .line1_stb(line1_stb), .rate_fast(rate_fast),
    .resync_in(resync_in), .resync_aud_en(resync_aud_en), .aud_len_m1(aud_len_m1),
    .vid_seq_mark(vid_seq_mark), .aud_seq_mark(aud_seq_mark), .aud_phase_rst(aud_phase_rst)
  );

  // stimulus rows: {rate, rs_mode[1:0], en, len_m1[3:0], exp_v, exp_a, exp_p, req[3:0]}
  localparam logic [14:0] VEC [14] = '{
    {1'b0, 2'd0, 1'b1, 4'd2, 3'b000, 4'd10},
    {1'b0, 2'd0, 1'b1, 4'd2, 3'b000, 4'd10},
    {1'b0, 2'd0, 1'b1, 4'd2, 3'b010, 4'd9},
    {1'b0, 2'd0, 1'b1, 4'd2, 3'b000, 4'd10},
    {1'b0, 2'd0, 1'b1, 4'd2, 3'b100, 4'd2},
    {1'b0, 2'd0, 1'b1, 4'd2, 3'b010, 4'd9},
    {1'b0, 2'd1, 1'b1, 4'd2, 3'b111, 4'd6},
    {1'b0, 2'd0, 1'b1, 4'd2, 3'b000, 4'd12},
    {1'b0, 2'd1, 1'b0, 4'd2, 3'b101, 4'd8},
    {1'b0, 2'd0, 1'b0, 4'd2, 3'b010, 4'd9},
    {1'b1, 2'd0, 1'b1, 4'd2, 3'b100, 4'd4},
    {1'b1, 2'd0, 1'b1, 4'd2, 3'b000, 4'd3},
    {1'b1, 2'd0, 1'b1, 4'd2, 3'b010, 4'd9},
    {1'b1, 2'd0, 1'b1, 4'd0, 3'b010, 4'd9}
  };

  function automatic string req_name(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic check3(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {vid,aud,phase} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // frame-level model of the requirements
  task automatic model_step(input bit rate, input bit apply, input bit en,
                            input int len_m1, output logic [2:0] exp);
    bit chg;
    int last;
    chg    = (rate != m_rate);
    m_rate = rate;
    last   = rate ? 9 : 4;
    if (apply || chg)       m_vid = 0;
    else if (m_vid >= last) m_vid = 0;
    else                    m_vid = m_vid + 1;
    if (apply && en)          m_aud = 0;
    else if (m_aud >= len_m1) m_aud = 0;
    else                      m_aud = m_aud + 1;
    exp = {m_vid == 0, m_aud == 0, apply};
  endtask

  // One frame. mode 0: no resync, 1: early pulse, 2: pulse reaching sync output
  // at the strobe edge, 3: pulse raised on the strobe cycle (too late).
  task automatic run_frame(input bit rate, input int mode, input bit en,
                           input int len_m1, output logic [2:0] got,
                           output logic [2:0] exp);
    bit apply;
    @(negedge clk);
    rate_fast = rate; resync_aud_en = en; aud_len_m1 = 4'(len_m1);
    if (mode == 1) begin
      resync_in = 1'b1; @(negedge clk); resync_in = 1'b0;
      repeat (5) @(negedge clk);
      line1_stb = 1'b1;
    end else if (mode == 2) begin
      resync_in = 1'b1; @(negedge clk); resync_in = 1'b0;
      @(negedge clk);
      line1_stb = 1'b1;
    end else if (mode == 3) begin
      repeat (4) @(negedge clk);
      resync_in = 1'b1; line1_stb = 1'b1;
    end else begin
      repeat (5) @(negedge clk);
      line1_stb = 1'b1;
    end
    @(negedge clk);
    line1_stb = 1'b0; resync_in = 1'b0;
    got = {vid_seq_mark, aud_seq_mark, aud_phase_rst};
    apply   = (mode == 1) || (mode == 2) || m_carry;
    m_carry = (mode == 3);
    model_step(rate, apply, en, len_m1, exp);
    @(negedge clk);
    check3("R11", {vid_seq_mark, aud_seq_mark, aud_phase_rst}, 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] got, exp;
    int last_v, last_a, idx;

    repeat (4) @(negedge clk);
    check3("R1", {vid_seq_mark, aud_seq_mark, aud_phase_rst}, 3'b000);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check3("R1", {vid_seq_mark, aud_seq_mark, aud_phase_rst}, 3'b000);

    // table walk
    for (int i = 0; i < 14; i++) begin
      run_frame(VEC[i][14], int'(VEC[i][13:12]), VEC[i][11], int'(VEC[i][10:7]), got, exp);
      check3(req_name(int'(VEC[i][3:0])), got, VEC[i][6:4]);
      check3(req_name(int'(VEC[i][3:0])), exp, VEC[i][6:4]);
    end

    // R3: spacing of 10 at the fast rate
    last_v = -1; idx = 0;
    for (int i = 0; i < 22; i++) begin
      run_frame(1'b1, 0, 1'b1, 2, got, exp);
      check3("R3", got, exp);
      if (got[2]) begin
        if (last_v >= 0) check_int("R3 spacing", idx - last_v, 10);
        last_v = idx;
      end
      idx++;
    end

    // R4 together with R5: rate change and resync at one strobe
    run_frame(1'b0, 1, 1'b1, 2, got, exp);
    check3("R4", got, 3'b111);

    // R2: spacing of 5 at the slow rate, free-running (R10)
    last_v = 0; idx = 1;
    for (int i = 0; i < 11; i++) begin
      run_frame(1'b0, 0, 1'b1, 2, got, exp);
      check3("R10", got, exp);
      if (got[2]) begin
        check_int("R2 spacing", idx - last_v, 5);
        last_v = idx;
      end
      idx++;
    end

    // R9: 16-frame audio period after a restart
    run_frame(1'b0, 1, 1'b1, 15, got, exp);
    check3("R7", got, exp);
    last_a = 0; idx = 1;
    for (int i = 0; i < 17; i++) begin
      run_frame(1'b0, 0, 1'b1, 15, got, exp);
      check3("R9", got, exp);
      if (got[1]) begin
        check_int("R9 spacing", idx - last_a, 16);
        last_a = idx;
      end
      idx++;
    end

    // R5: synchronised level meets the strobe in the same cycle
    run_frame(1'b0, 2, 1'b1, 2, got, exp);
    check3("R5", got, exp);
    check3("R5", got, {2'b11, 1'b1});

    // R12: too-late request waits for the following strobe, then clears
    run_frame(1'b0, 3, 1'b1, 2, got, exp);
    check3("R12", got, exp);
    check_int("R12 not early", int'(got[0]), 0);
    run_frame(1'b0, 0, 1'b1, 2, got, exp);
    check3("R12", got, 3'b111);
    run_frame(1'b0, 0, 1'b1, 2, got, exp);
    check3("R12", got, exp);
    check_int("R12 cleared", int'(got[0]), 0);

    // R8: mask cleared leaves the audio sequence running
    run_frame(1'b0, 1, 1'b0, 2, got, exp);
    check3("R8", got, exp);
    check_int("R8 phase", int'(got[0]), 1);

    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check3("R1", {vid_seq_mark, aud_seq_mark, aud_phase_rst}, 3'b000);
    rst_n = 1'b1;
    m_vid = 0; m_aud = 0; m_rate = 1'b0; m_carry = 1'b0;
    run_frame(1'b0, 0, 1'b1, 2, got, exp);
    check3("R1", got, 3'b000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule